// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This unit turns a 64-bit integer operand into a binary floating-point value delivered in 64-bit double format. A 2-bit type code states how the operand is read: as a signed or unsigned integer, either 32 or 64 bits wide. A mode input picks the target precision. In double mode the result is a 64-bit double. In single mode the value is rounded to a 24-bit significand and then widened, without further change, to double format. Rounding obeys a 2-bit rounding-mode input.

The unit computes the result in one pass of logic and registers every output on the next rising clock, so there is one cycle of latency and a new conversion can start on every cycle. Besides the result it reports an inexact flag, an enable that tells the status register whether this conversion may change its flags, and a 5-bit class code for the result. Instruction decode, register files and condition-register writes are handled outside this block.

Top module: `i2f_convert`

## Requirements
- R1: Type code 0 reads the operand as signed 32-bit, 1 as unsigned 32-bit, 2 as signed 64-bit and 3 as unsigned 64-bit. For the 32-bit codes bits 63:32 of the operand have no effect on any output.
- R2: In double mode (single_i = 0) with type code bit 1 clear, the conversion is exact, flag_upd_o is 0 and inexact_o is 0.
- R3: In double mode with type code bit 1 set, the value is rounded to a 53-bit significand under rmode_i and flag_upd_o is 1.
- R4: In single mode, every type code rounds the value to a 24-bit significand under rmode_i, flag_upd_o is 1, and the result is that value in double format, so bits 28:0 of result_o are 0.
- R5: rmode_i encodes 0 = round to nearest with ties to even, 1 = toward zero, 2 = toward plus infinity, 3 = toward minus infinity.
- R6: inexact_o is 1 exactly when flag_upd_o is 1 and rounding dropped nonzero bits of the value.
- R7: A zero value gives result_o = 0 (plus zero) with class_o = 5'b00010; a positive nonzero result gives class_o = 5'b00100 and a negative one gives 5'b01000, with bit 63 of result_o set.
- R8: Signed 64-bit -2^63 converts exactly to 64'hC3E0000000000000; unsigned 2^64-1 in double mode gives 64'h43F0000000000000 under nearest-even and 64'h43EFFFFFFFFFFFFF toward zero.
- R9: All outputs are registered: they take the values for the inputs present at a rising clock edge and hold them until the next edge; while rst_ni is low all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Integer operand |
| itype_i | input | 2 | Operand type code |
| single_i | input | 1 | 1 = round to single precision, 0 = double |
| rmode_i | input | 2 | Rounding mode |
| result_o | output | 64 | Converted value in double format |
| inexact_o | output | 1 | Rounding dropped nonzero bits |
| flag_upd_o | output | 1 | Status flags may be updated by this conversion |
| class_o | output | 5 | Result class code |

## Verification
The hardest situations to reach are exact ties at the rounding point and the carry that a round-up pushes into the exponent, since a random 64-bit operand almost never sits halfway between two representable values. The stimulus builds them on purpose: operands of the form 2^53 plus one or three, 2^24 plus one, and all-ones values whose round-up crosses a power of two, each driven under all four rounding modes with both signs. A reference model in the bench, written with plain integer division by powers of two and remainder comparison, supplies the expected result for every vector, and a few hand-computed constants anchor it.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned DBL_MW = 53;
  localparam int unsigned SGL_MW = 24;
  localparam int unsigned CLS_W  = 5;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_POS  = 2'd2,
    RM_NEG  = 2'd3
  } rmode_e;

  localparam logic [CLS_W-1:0] CLS_ZERO = 5'b00010;
  localparam logic [CLS_W-1:0] CLS_POS  = 5'b00100;
  localparam logic [CLS_W-1:0] CLS_NEG  = 5'b01000;
endpackage

// File: rtl/i2f_operand.sv
module i2f_operand #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] src_i,
  input  logic [1:0]   itype_i,
  output logic         neg_o,
  output logic [W-1:0] mag_o
);
  localparam int unsigned HW = W / 2;

  logic [W-1:0] ext;

  always_comb begin
    // bit 1: wide source, bit 0: unsigned
    if (itype_i[1]) ext = src_i;
    else            ext = {{HW{~itype_i[0] & src_i[HW-1]}}, src_i[HW-1:0]};
    neg_o = ~itype_i[0] & ext[W-1];
    mag_o = neg_o ? (~ext + 1'b1) : ext;
  end
endmodule

// File: rtl/i2f_normalize.sv
module i2f_normalize #(
  parameter int unsigned W     = 64,
  parameter int unsigned CNT_W = $clog2(W)
) (
  input  logic [W-1:0]     mag_i,
  output logic [W-1:0]     norm_o,
  output logic [CNT_W-1:0] lz_o
);
  always_comb begin
    lz_o = '1;
    for (int i = 0; i < W; i++) begin
      if (mag_i[i]) lz_o = CNT_W'(W - 1 - i);
    end
    norm_o = mag_i << lz_o;
  end
endmodule

// File: rtl/i2f_round.sv
module i2f_round
  import i2f_pkg::*;
#(
  parameter int unsigned W  = 64,
  parameter int unsigned MW = 53
) (
  input  logic [W-1:0] norm_i,
  input  logic         neg_i,
  input  rmode_e       rmode_i,
  output logic [MW:0]  sum_o,
  output logic         inexact_o
);
  localparam int unsigned REST_W = W - MW;

  logic guard, sticky, lsb, inc;

  always_comb begin
    lsb    = norm_i[REST_W];
    guard  = norm_i[REST_W-1];
    sticky = |norm_i[REST_W-2:0];
    unique case (rmode_i)
      RM_NEAR: inc = guard & (sticky | lsb);
      RM_ZERO: inc = 1'b0;
      RM_POS:  inc = ~neg_i & (guard | sticky);
      RM_NEG:  inc = neg_i & (guard | sticky);
      default: inc = 1'b0;
    endcase
    inexact_o = guard | sticky;
    // sum_o[MW] set means the significand wrapped to the next power of two
    sum_o = {1'b0, norm_i[W-1 -: MW]} + {{MW{1'b0}}, inc};
  end
endmodule

// File: rtl/i2f_convert.sv
module i2f_convert
  import i2f_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [63:0] src_i,
  input  logic [1:0]  itype_i,
  input  logic        single_i,
  input  logic [1:0]  rmode_i,
  output logic [63:0] result_o,
  output logic        inexact_o,
  output logic        flag_upd_o,
  output logic [4:0]  class_o
);
  localparam int unsigned CNT_W  = $clog2(XLEN);
  localparam int unsigned BIAS   = 1023;
  localparam int unsigned FRAC_W = DBL_MW - 1;
  localparam int unsigned PAD_W  = DBL_MW - SGL_MW;

  logic             neg;
  logic [XLEN-1:0]  mag, norm;
  logic [CNT_W-1:0] lz;
  logic [DBL_MW:0]  sum_d;
  logic [SGL_MW:0]  sum_s;
  logic             inx_d, inx_s;

  i2f_operand #(.W(XLEN)) u_operand (
    .src_i   (src_i),
    .itype_i (itype_i),
    .neg_o   (neg),
    .mag_o   (mag)
  );

  i2f_normalize #(.W(XLEN), .CNT_W(CNT_W)) u_norm (
    .mag_i  (mag),
    .norm_o (norm),
    .lz_o   (lz)
  );

  i2f_round #(.W(XLEN), .MW(DBL_MW)) u_rnd_dbl (
    .norm_i    (norm),
    .neg_i     (neg),
    .rmode_i   (rmode_e'(rmode_i)),
    .sum_o     (sum_d),
    .inexact_o (inx_d)
  );

  i2f_round #(.W(XLEN), .MW(SGL_MW)) u_rnd_sgl (
    .norm_i    (norm),
    .neg_i     (neg),
    .rmode_i   (rmode_e'(rmode_i)),
    .sum_o     (sum_s),
    .inexact_o (inx_s)
  );

  logic              carry, hidden, nonzero, upd, inx;
  logic [FRAC_W-1:0] frac;
  logic [CNT_W:0]    exp_unb;
  logic [10:0]       exp_b;
  logic [63:0]       res_d;
  logic [4:0]        cls_d;

  always_comb begin
    if (single_i) begin
      carry  = sum_s[SGL_MW];
      hidden = sum_s[SGL_MW-1];
      frac   = {sum_s[SGL_MW-2:0], {PAD_W{1'b0}}};
      inx    = inx_s;
    end else begin
      carry  = sum_d[DBL_MW];
      hidden = sum_d[DBL_MW-1];
      frac   = sum_d[DBL_MW-2:0];
      inx    = inx_d;
    end
    nonzero = hidden | carry;
    upd     = single_i | itype_i[1];
    exp_unb = (CNT_W+1)'(XLEN - 1) - {1'b0, lz} + {{CNT_W{1'b0}}, carry};
    exp_b   = 11'(BIAS) + {{(11-CNT_W-1){1'b0}}, exp_unb};
    if (nonzero) begin
      res_d = {neg, exp_b, frac};
      cls_d = neg ? CLS_NEG : CLS_POS;
    end else begin
      res_d = '0;
      cls_d = CLS_ZERO;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o   <= '0;
      inexact_o  <= 1'b0;
      flag_upd_o <= 1'b0;
      class_o    <= '0;
    end else begin
      result_o   <= res_d;
      inexact_o  <= upd & nonzero & inx;
      flag_upd_o <= upd;
      class_o    <= cls_d;
    end
  end
endmodule

// File: rtl/i2f_convert_chk.sv
module i2f_convert_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [63:0] src_i,
  input logic [1:0]  itype_i,
  input logic        single_i,
  input logic [1:0]  rmode_i,
  input logic [63:0] result_o,
  input logic        inexact_o,
  input logic        flag_upd_o,
  input logic [4:0]  class_o
);
  assert_unsigned_nonneg_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    itype_i[0] |=> !result_o[63]);

  assert_exact_no_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!single_i && !itype_i[1]) |=> (!flag_upd_o && !inexact_o));

  assert_wide_updates_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!single_i && itype_i[1]) |=> flag_upd_o);

  assert_single_format_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_i |=> (flag_upd_o && result_o[28:0] == 29'd0));

  assert_inexact_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inexact_o |-> flag_upd_o);

  assert_zero_class_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == 64'd0) |=> (result_o == 64'd0 && class_o == 5'b00010));

  assert_neg_sign_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_o == 5'b01000) |-> result_o[63]);

  assert_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable({src_i, itype_i, single_i, rmode_i}) |=> $stable(result_o));

  logic unused_rm;
  assign unused_rm = ^rmode_i;
endmodule

bind i2f_convert i2f_convert_chk u_i2f_convert_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_i      (src_i),
  .itype_i    (itype_i),
  .single_i   (single_i),
  .rmode_i    (rmode_i),
  .result_o   (result_o),
  .inexact_o  (inexact_o),
  .flag_upd_o (flag_upd_o),
  .class_o    (class_o)
);

// File: tb/test_i2f_convert.sv
module test_i2f_convert;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] src_i = '0;
  logic [1:0]  itype_i = '0;
  logic        single_i = 1'b0;
  logic [1:0]  rmode_i = '0;
  logic [63:0] result_o;
  logic        inexact_o, flag_upd_o;
  logic [4:0]  class_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  i2f_convert i_i2f_convert (
    .clk_i, .rst_ni, .src_i, .itype_i, .single_i, .rmode_i,
    .result_o, .inexact_o, .flag_upd_o, .class_o
  );

  function automatic logic [63:0] next_rnd();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  // reference: division by powers of two and remainder comparison
  function automatic logic [63:0] ref_conv(input logic [63:0] s, input logic [1:0] it,
                                           input logic sg, input logic [1:0] rm,
                                           output logic inx);
    logic neg;
    logic [63:0] mag, rem, half;
    logic [64:0] kept;
    logic up;
    int msb, p, k, km;
    logic [63:0] fr;
    inx = 1'b0;
    case (it)
      2'd0: begin neg = s[31]; mag = neg ? {32'd0, ~s[31:0] + 32'd1} : {32'd0, s[31:0]}; end
      2'd1: begin neg = 1'b0; mag = {32'd0, s[31:0]}; end
      2'd2: begin neg = s[63]; mag = neg ? ~s + 64'd1 : s; end
      default: begin neg = 1'b0; mag = s; end
    endcase
    if (mag == 64'd0) return 64'd0;
    msb = 63;
    while (!mag[msb]) msb--;
    p = sg ? 24 : 53;
    k = msb - (p - 1);
    if (k <= 0) begin
      k = 0; kept = {1'b0, mag};
    end else begin
      kept = {1'b0, mag >> k};
      rem  = mag & ((64'd1 << k) - 64'd1);
      half = 64'd1 << (k - 1);
      inx  = (rem != 0);
      case (rm)
        2'd0: up = (rem > half) || (rem == half && kept[0]);
        2'd1: up = 1'b0;
        2'd2: up = !neg && inx;
        default: up = neg && inx;
      endcase
      kept = kept + 65'(up);
      if (kept == (65'd1 << p)) begin kept = kept >> 1; k++; end
    end
    km = 0;
    for (int i = 0; i < 64; i++) if (kept[i]) km = i;
    fr = kept[63:0] << (52 - km);
    return {neg, 11'(km + k + 1023), fr[51:0]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [63:0] s, input logic [1:0] it, input logic sg, input logic [1:0] rm);
    @(negedge clk_i);
    src_i = s; itype_i = it; single_i = sg; rmode_i = rm;
    @(negedge clk_i);
  endtask

  task automatic apply(input string tag, input logic [63:0] s, input logic [1:0] it,
                       input logic sg, input logic [1:0] rm);
    logic [63:0] er;
    logic ei;
    logic [4:0] ec;
    er = ref_conv(s, it, sg, rm, ei);
    ec = (er == 0) ? 5'b00010 : (er[63] ? 5'b01000 : 5'b00100);
    drive(s, it, sg, rm);
    chk({tag, " result"}, result_o, er);
    chk({tag, " inexact R6"}, {63'd0, inexact_o}, {63'd0, ei & (sg | it[1])});
    chk({tag, " flag_upd"}, {63'd0, flag_upd_o}, {63'd0, sg | it[1]});
    chk({tag, " class R7"}, {59'd0, class_o}, {59'd0, ec});
  endtask

  task automatic t_reset();
    #1;
    chk("R9 reset result", result_o, 64'd0);
    chk("R9 reset flags", {61'd0, inexact_o, flag_upd_o, 1'b0}, 64'd0);
    chk("R9 reset class", {59'd0, class_o}, 64'd0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_known();
    drive(64'd1, 2'd3, 1'b0, 2'd0);
    chk("R3 one", result_o, 64'h3FF0000000000000);
    drive(64'hFFFFFFFF_FFFFFFFF, 2'd0, 1'b0, 2'd0);
    chk("R2 minus one", result_o, 64'hBFF0000000000000);
    chk("R7 neg class", {59'd0, class_o}, 64'd8);
    drive(64'h80000000_00000000, 2'd2, 1'b0, 2'd0);
    chk("R8 min s64", result_o, 64'hC3E0000000000000);
    chk("R8 min s64 exact", {63'd0, inexact_o}, 64'd0);
    drive(64'hFFFFFFFF_FFFFFFFF, 2'd3, 1'b0, 2'd0);
    chk("R8 max u64 nearest", result_o, 64'h43F0000000000000);
    chk("R8 max u64 inexact", {63'd0, inexact_o}, 64'd1);
    drive(64'hFFFFFFFF_FFFFFFFF, 2'd3, 1'b0, 2'd1);
    chk("R8 max u64 zero R5", result_o, 64'h43EFFFFFFFFFFFFF);
    drive(64'd16777217, 2'd1, 1'b1, 2'd0);
    chk("R4 tie even single", result_o, 64'h4170000000000000);
    drive(64'd16777217, 2'd1, 1'b1, 2'd2);
    chk("R5 up single", result_o, 64'h4170000020000000);
    drive(64'd0, 2'd2, 1'b1, 2'd3);
    chk("R7 zero", result_o, 64'd0);
    chk("R7 zero class", {59'd0, class_o}, 64'd2);
  endtask

  task automatic t_upper_ignored();
    drive(64'hDEADBEEF_00000005, 2'd1, 1'b0, 2'd0);
    chk("R1 upper ignored u32", result_o, 64'h4014000000000000);
    drive(64'h12345678_FFFFFFFF, 2'd0, 1'b0, 2'd0);
    chk("R1 upper ignored s32", result_o, 64'hBFF0000000000000);
    drive(64'hFFFFFFFF_00000000, 2'd0, 1'b1, 2'd2);
    chk("R1 upper ignored zero", result_o, 64'd0);
  endtask

  task automatic t_exact32();
    for (int it = 0; it < 2; it++)
      for (int n = 0; n < 10; n++)
        apply("R2 exact32", next_rnd(), 2'(it), 1'b0, 2'(n % 4));
    apply("R2 s32 min", 64'h00000000_80000000, 2'd0, 1'b0, 2'd1);
    apply("R2 u32 max", 64'h00000000_FFFFFFFF, 2'd1, 1'b0, 2'd3);
  endtask

  task automatic t_double64();
    logic [63:0] ties [6] = '{64'h0020000000000001, 64'h0020000000000003,
                              64'hFFDFFFFFFFFFFFFF, 64'h7FFFFFFFFFFFFFFF,
                              64'h8000000000000401, 64'h003FFFFFFFFFFFFF};
    for (int rm = 0; rm < 4; rm++)
      for (int it = 2; it < 4; it++) begin
        for (int n = 0; n < 6; n++) apply("R3 R5 double64", ties[n], 2'(it), 1'b0, 2'(rm));
        for (int n = 0; n < 6; n++) apply("R3 R5 double64 rnd", next_rnd(), 2'(it), 1'b0, 2'(rm));
      end
  endtask

  task automatic t_single();
    logic [63:0] ties [4] = '{64'h0000000001000001, 64'h0000000001000003,
                              64'hFFFFFFFFFEFFFFFF, 64'h00000000FFFFFFFF};
    for (int rm = 0; rm < 4; rm++)
      for (int it = 0; it < 4; it++) begin
        for (int n = 0; n < 4; n++) apply("R4 R5 single", ties[n], 2'(it), 1'b1, 2'(rm));
        for (int n = 0; n < 4; n++) apply("R4 R5 single rnd", next_rnd(), 2'(it), 1'b1, 2'(rm));
      end
  endtask

  task automatic t_latency();
    drive(64'd2, 2'd3, 1'b0, 2'd0);
    @(negedge clk_i);
    src_i = 64'd3;
    #1;
    chk("R9 holds before edge", result_o, 64'h4000000000000000);
    @(negedge clk_i);
    chk("R9 updates after edge", result_o, 64'h4008000000000000);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_known();
    t_upper_ignored();
    t_exact32();
    t_double64();
    t_single();
    t_latency();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule